// File: doc/BRIEF.md
# Cache-Miss Load Replay Set

This block parks ordinary cacheable loads that were issued speculatively and then came back from the first-level data cache as a miss, or as a hit on a line that is not ready yet. Each parked load has one slot, and the slot is picked by the load's load-queue index. A parked load stays put until the cache signals that the line has been filled for that index, or until the load is squashed. At that point the block hands the load back to the issue logic so that it can execute again.

A miss report always produces a cancel pulse for the load's dependent instructions in the same cycle. The report also carries attribute bits. Atomic (load-linked) loads and uncacheable loads are never parked; they keep their normal completion path. For a cacheable report the block also sends a slot-clear pulse to the load queue. That pulse tells the load queue to drop the slot's pending request and to reset its translation, address-valid and can-issue state.

The replay port is shared with loads that were deferred for translation. Parked loads that are ready to leave always go ahead of deferred loads. The block also drives an activity flag, which tells the scheduler not to go idle while any load is parked.

Top module: `ld_miss_replay_set`

## Requirements
- R1: A report with `rpt_valid`=1, `rpt_atomic`=0 and `rpt_uncached`=0 parks the load under `rpt_idx` from the next cycle on. A report with either attribute bit set parks nothing.
- R2: Every report, whatever its attribute bits, drives `cancel_valid`=1 with `cancel_idx`=`rpt_idx` in the same cycle.
- R3: `slot_clr_valid` pulses with `slot_clr_idx`=`rpt_idx` in the same cycle as each cacheable report, including a repeated one. It never pulses for atomic or uncacheable reports.
- R4: A cacheable report for an index that is already parked changes nothing. The existing slot keeps the fill and squash marks it already has.
- R5: A parked load is not offered on the replay port until a fill for its index (`fill_valid`, `fill_idx`) or a squash for it has been recorded.
- R6: A fill or squash for an index that is not parked is ignored. Inserting that index later still requires a fresh fill or squash before it is released.
- R7: A fill or squash that arrives in the same cycle as the insert of its index is recorded. The load becomes eligible for release in the next cycle.
- R8: When several parked loads are eligible, one is offered per cycle, lowest index first. A live load leaves the set only on `rep_valid`&`rep_ready`, and it is held on the port while `rep_ready` is low.
- R9: A squashed load is offered with `rep_squashed`=1 and `rep_from_set`=1. It leaves the set in the cycle it is offered, whatever the value of `rep_ready`.
- R10: An eligible parked load takes the replay port ahead of the deferred input. `defer_ready`=`rep_ready` only while no parked load is eligible; otherwise it is 0. When the set path is not offering, the port carries `defer_valid`/`defer_idx` with `rep_from_set`=0.
- R11: `active` is 1 exactly when at least one load is parked, judged from the registered state.
- R12: After a synchronous active-low reset the set is empty. `active` is 0, and `rep_valid` follows `defer_valid` only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rpt_valid | input | 1 | Miss or not-ready report from the data cache |
| rpt_idx | input | IDX_W | Load-queue index of the reported load |
| rpt_atomic | input | 1 | Reported load is a load-linked/atomic access |
| rpt_uncached | input | 1 | Reported load is uncacheable |
| fill_valid | input | 1 | Line fill finished for a parked load |
| fill_idx | input | IDX_W | Load-queue index the fill belongs to |
| squash_vec | input | LQ_DEPTH | One bit per load-queue index being squashed this cycle |
| defer_valid | input | 1 | A translation-deferred load requests the replay port |
| defer_idx | input | IDX_W | Load-queue index of the deferred load |
| defer_ready | output | 1 | Deferred load accepted by the port this cycle |
| rep_valid | output | 1 | Replay port offers a load |
| rep_ready | input | 1 | Issue logic takes the offered load |
| rep_idx | output | IDX_W | Load-queue index being replayed |
| rep_squashed | output | 1 | Offered load was squashed and is to be dropped |
| rep_from_set | output | 1 | Offered load comes from the parked set |
| cancel_valid | output | 1 | Cancel the dependents of the reported load |
| cancel_idx | output | IDX_W | Load-queue index whose dependents are cancelled |
| slot_clr_valid | output | 1 | Clear pending request and issue state of a load-queue slot |
| slot_clr_idx | output | IDX_W | Load-queue slot to clear |
| active | output | 1 | At least one load is parked |

## Verification
The assertions assume that the issue logic leaves `rep_ready` free to change. They do not assume that the port is ever drained. They also assume that a fill arrives only on a valid `fill_idx`, and that attribute bits are meaningful only while `rpt_valid` is high. The stimulus holds `rpt_*` and `fill_*` at zero whenever their valid bits are low, so it stays inside those assumptions. It also keeps every index below `LQ_DEPTH`. Sequences are chosen so that duplicates, same-cycle fill and squash, and back-pressure each line up with a known set content.

// File: rtl/lrq_pkg.sv
// Package lrq_pkg
// Shared types for the cache-miss load replay set.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package lrq_pkg;

    // State kept for one parked load slot.
    typedef struct packed {
        logic valid;     // slot holds a parked load
        logic refilled;  // line fill for this load has arrived
        logic squashed;  // load was squashed while parked
    } lrq_slot_t;

    localparam lrq_slot_t LRQ_SLOT_EMPTY = '{valid: 1'b0, refilled: 1'b0, squashed: 1'b0};

endpackage

// File: rtl/lrq_report_filter.sv
// Module lrq_report_filter
// Classifies a cache miss/not-ready report. Every report cancels dependents;
// only cacheable, non-atomic reports request an insert and a slot clear.
// Assumes: attribute bits are only meaningful while rpt_valid is high.
module lrq_report_filter #(
    parameter int IDX_W = 4
) (
    input  logic             rpt_valid,
    input  logic [IDX_W-1:0] rpt_idx,
    input  logic             rpt_atomic,
    input  logic             rpt_uncached,
    output logic             cancel_valid,
    output logic [IDX_W-1:0] cancel_idx,
    output logic             ins_req,
    output logic [IDX_W-1:0] ins_idx
);

    logic bypass;

    // Decide whether the reported load is of a kind that must not be parked.
    always_comb begin
        bypass       = rpt_atomic | rpt_uncached;
        cancel_valid = rpt_valid;
        cancel_idx   = rpt_idx;
        ins_req      = rpt_valid & ~bypass;
        ins_idx      = rpt_idx;
    end

endmodule

// File: rtl/lrq_slot.sv
// Module lrq_slot
// One parked-load slot. An insert takes effect only when the slot is empty,
// and fill/squash marks that arrive with the insert are captured. Marks for an
// empty slot are ignored otherwise. A pop empties the slot.
// Assumes: pop is only raised while the slot is valid.
module lrq_slot
    import lrq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ins_hit,
    input  logic      fill_hit,
    input  logic      squash_hit,
    input  logic      pop,
    output lrq_slot_t state
);

    // Slot state update: reset, insert, pop, or accumulate fill/squash marks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LRQ_SLOT_EMPTY;
        end else if (!state.valid) begin
            if (ins_hit) begin
                state.valid    <= 1'b1;
                state.refilled <= fill_hit;
                state.squashed <= squash_hit;
            end
        end else if (pop) begin
            state <= LRQ_SLOT_EMPTY;
        end else begin
            state.refilled <= state.refilled | fill_hit;
            state.squashed <= state.squashed | squash_hit;
        end
    end

endmodule

// File: rtl/lrq_pick_lowest.sv
// Module lrq_pick_lowest
// Fixed-priority picker: reports whether any request bit is set and the index
// of the lowest set bit.
// Assumes: N fits in IDX_W bits.
module lrq_pick_lowest #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) begin
                found = 1'b1;
                idx   = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/ld_miss_replay_set.sv
// Module ld_miss_replay_set
// Parks cacheable loads that missed (or hit a not-ready line) under their
// load-queue index. A load is released once its fill or a squash has been
// recorded, one per cycle and lowest index first. Released loads take the
// shared replay port ahead of translation-deferred loads.
// Assumes: indices presented on any input are below LQ_DEPTH.
module ld_miss_replay_set
    import lrq_pkg::*;
#(
    parameter int LQ_DEPTH = 16,
    localparam int IDX_W   = (LQ_DEPTH > 1) ? $clog2(LQ_DEPTH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rpt_valid,
    input  logic [IDX_W-1:0]    rpt_idx,
    input  logic                rpt_atomic,
    input  logic                rpt_uncached,
    input  logic                fill_valid,
    input  logic [IDX_W-1:0]    fill_idx,
    input  logic [LQ_DEPTH-1:0] squash_vec,
    input  logic                defer_valid,
    input  logic [IDX_W-1:0]    defer_idx,
    output logic                defer_ready,
    output logic                rep_valid,
    input  logic                rep_ready,
    output logic [IDX_W-1:0]    rep_idx,
    output logic                rep_squashed,
    output logic                rep_from_set,
    output logic                cancel_valid,
    output logic [IDX_W-1:0]    cancel_idx,
    output logic                slot_clr_valid,
    output logic [IDX_W-1:0]    slot_clr_idx,
    output logic                active
);

    logic               ins_req;
    logic [IDX_W-1:0]   ins_idx;
    lrq_slot_t          slot_q   [LQ_DEPTH];
    logic [LQ_DEPTH-1:0] slot_valid;
    logic [LQ_DEPTH-1:0] slot_squashed;
    logic [LQ_DEPTH-1:0] eligible;
    logic [LQ_DEPTH-1:0] pop_vec;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               pick_squashed;

    lrq_report_filter #(.IDX_W(IDX_W)) u_filter (
        .rpt_valid    (rpt_valid),
        .rpt_idx      (rpt_idx),
        .rpt_atomic   (rpt_atomic),
        .rpt_uncached (rpt_uncached),
        .cancel_valid (cancel_valid),
        .cancel_idx   (cancel_idx),
        .ins_req      (ins_req),
        .ins_idx      (ins_idx)
    );

    // One slot per load-queue index, with its own index decode.
    for (genvar i = 0; i < LQ_DEPTH; i++) begin : g_slot
        logic ins_hit;
        logic fill_hit;

        // Decode insert and fill targets for this slot.
        always_comb begin
            ins_hit  = ins_req & (ins_idx == IDX_W'(i));
            fill_hit = fill_valid & (fill_idx == IDX_W'(i));
        end

        lrq_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .ins_hit    (ins_hit),
            .fill_hit   (fill_hit),
            .squash_hit (squash_vec[i]),
            .pop        (pop_vec[i]),
            .state      (slot_q[i])
        );

        // Flatten slot state into vectors used by the picker and status.
        always_comb begin
            slot_valid[i]    = slot_q[i].valid;
            slot_squashed[i] = slot_q[i].squashed;
            eligible[i]      = slot_q[i].valid & (slot_q[i].refilled | slot_q[i].squashed);
            pop_vec[i]       = pick_found & (pick_idx == IDX_W'(i)) & (rep_ready | slot_q[i].squashed);
        end
    end

    lrq_pick_lowest #(.N(LQ_DEPTH), .IDX_W(IDX_W)) u_pick (
        .req   (eligible),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Replay port arbitration: parked set first, deferred loads otherwise.
    always_comb begin
        pick_squashed = slot_squashed[pick_idx];
        rep_from_set  = pick_found;
        rep_valid     = pick_found | defer_valid;
        rep_idx       = pick_found ? pick_idx : defer_idx;
        rep_squashed  = pick_found & pick_squashed;
        defer_ready   = rep_ready & ~pick_found;
    end

    // Slot-clear request to the load queue and activity flag.
    always_comb begin
        slot_clr_valid = ins_req;
        slot_clr_idx   = ins_idx;
        active         = |slot_valid;
    end

endmodule

// File: rtl/lrq_checker.sv
// Module lrq_checker
// Temporal checks on the replay set's ports, bound to every instance.
// Assumes: indices stay below the configured depth.
module lrq_checker #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rpt_valid,
    input logic [IDX_W-1:0] rpt_idx,
    input logic             rpt_atomic,
    input logic             rpt_uncached,
    input logic             rep_valid,
    input logic             rep_ready,
    input logic [IDX_W-1:0] rep_idx,
    input logic             rep_squashed,
    input logic             rep_from_set,
    input logic             defer_ready,
    input logic             cancel_valid,
    input logic [IDX_W-1:0] cancel_idx,
    input logic             slot_clr_valid,
    input logic [IDX_W-1:0] slot_clr_idx,
    input logic             active
);

    assert_bypass_not_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && rpt_valid && (rpt_atomic || rpt_uncached)) |=> !active);

    assert_cancel_follows_report_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_valid |-> (rpt_valid && cancel_idx == rpt_idx));

    assert_slot_clear_cacheable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        slot_clr_valid |-> (rpt_valid && !rpt_atomic && !rpt_uncached && slot_clr_idx == rpt_idx));

    assert_hold_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_from_set && !rep_ready && !rep_squashed)
        |=> (rep_valid && rep_from_set && rep_idx <= $past(rep_idx)));

    assert_squash_leaves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_from_set && rep_squashed)
        |=> !(rep_valid && rep_from_set && rep_squashed && rep_idx == $past(rep_idx)));

    assert_set_before_defer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        defer_ready |-> !(rep_valid && rep_from_set));

    assert_insert_marks_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && !rpt_atomic && !rpt_uncached && !(rep_valid && rep_from_set)) |=> active);

    assert_release_needs_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && rep_from_set) |-> active);

endmodule

bind ld_miss_replay_set lrq_checker #(.IDX_W(IDX_W)) u_lrq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .rpt_valid      (rpt_valid),
    .rpt_idx        (rpt_idx),
    .rpt_atomic     (rpt_atomic),
    .rpt_uncached   (rpt_uncached),
    .rep_valid      (rep_valid),
    .rep_ready      (rep_ready),
    .rep_idx        (rep_idx),
    .rep_squashed   (rep_squashed),
    .rep_from_set   (rep_from_set),
    .defer_ready    (defer_ready),
    .cancel_valid   (cancel_valid),
    .cancel_idx     (cancel_idx),
    .slot_clr_valid (slot_clr_valid),
    .slot_clr_idx   (slot_clr_idx),
    .active         (active)
);

// File: tb/ld_miss_replay_set_tb.sv
`timescale 1ns/1ps
module ld_miss_replay_set_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rpt_valid = 1'b0, rpt_atomic = 1'b0, rpt_uncached = 1'b0;
    logic [3:0]  rpt_idx = '0;
    logic        fill_valid = 1'b0;
    logic [3:0]  fill_idx = '0;
    logic [15:0] squash_vec = '0;
    logic        defer_valid = 1'b0;
    logic [3:0]  defer_idx = '0;
    logic        defer_ready, rep_valid, rep_squashed, rep_from_set;
    logic        rep_ready = 1'b0;
    logic [3:0]  rep_idx, cancel_idx, slot_clr_idx;
    logic        cancel_valid, slot_clr_valid, active;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ld_miss_replay_set #(.LQ_DEPTH(16)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rpt_valid(rpt_valid), .rpt_idx(rpt_idx), .rpt_atomic(rpt_atomic), .rpt_uncached(rpt_uncached),
        .fill_valid(fill_valid), .fill_idx(fill_idx), .squash_vec(squash_vec),
        .defer_valid(defer_valid), .defer_idx(defer_idx), .defer_ready(defer_ready),
        .rep_valid(rep_valid), .rep_ready(rep_ready), .rep_idx(rep_idx),
        .rep_squashed(rep_squashed), .rep_from_set(rep_from_set),
        .cancel_valid(cancel_valid), .cancel_idx(cancel_idx),
        .slot_clr_valid(slot_clr_valid), .slot_clr_idx(slot_clr_idx), .active(active)
    );

    typedef struct packed {
        logic        rv; logic [3:0] ri; logic ra; logic ru;
        logic        fv; logic [3:0] fi;
        logic [15:0] sq;
        logic        dv; logic [3:0] di;
        logic        rr;
        logic        e_rv; logic [3:0] e_ri; logic e_rs; logic e_set;
        logic        e_dr; logic e_cl; logic e_act;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd7, 1'b1, 1'b1,4'd7,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{1'b1,4'd5,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b1,1'b0},
        '{1'b1,4'd9,1'b1,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b1},
        '{1'b1,4'd10,1'b0,1'b1, 1'b1,4'd12, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b1},
        '{1'b1,4'd12,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd2, 1'b1, 1'b1,4'd2,1'b0,1'b0, 1'b1,1'b1,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b1,4'd5, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd3, 1'b0, 1'b1,4'd5,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd3, 1'b0, 1'b1,4'd5,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b1,4'd5,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd3, 1'b0, 1'b1,4'd5,1'b0,1'b1, 1'b0,1'b1,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd3, 1'b0, 1'b1,4'd5,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd3, 1'b1, 1'b1,4'd5,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b1,4'd3, 1'b1, 1'b1,4'd3,1'b0,1'b0, 1'b1,1'b0,1'b1},
        '{1'b1,4'd1,1'b0,1'b0, 1'b1,4'd1, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b1,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b1,4'd12, 16'h0000, 1'b0,4'd0, 1'b0, 1'b1,4'd1,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b0, 1'b1,4'd1,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b1,4'd1,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b1,4'd12,1'b0,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b0},
        '{1'b1,4'd4,1'b0,1'b0, 1'b0,4'd0, 16'h0050, 1'b0,4'd0, 1'b0, 1'b0,4'd0,1'b0,1'b0, 1'b0,1'b1,1'b0},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b0, 1'b1,4'd4,1'b1,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b0, 1'b0,4'd0,1'b0,1'b0, 1'b0,1'b0,1'b0},
        '{1'b1,4'd6,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b0, 1'b0,4'd0,1'b0,1'b0, 1'b0,1'b1,1'b0},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0040, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b1,4'd6,1'b1,1'b1, 1'b0,1'b0,1'b1},
        '{1'b0,4'd0,1'b0,1'b0, 1'b0,4'd0, 16'h0000, 1'b0,4'd0, 1'b1, 1'b0,4'd0,1'b0,1'b0, 1'b1,1'b0,1'b0}
    };

    // Requirement each table row is mainly aimed at.
    function automatic string row_tag(int r);
        case (r)
            1:              return "R1";
            2:              return "R2";
            3, 21, 22:      return "R6";
            5:              return "R5";
            8, 9:           return "R4";
            12, 13, 18:     return "R7";
            19, 20, 23, 24: return "R9";
            17, 25:         return "R11";
            0, 4, 11:       return "R10";
            default:        return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic drive_idle();
        rpt_valid = 0; rpt_idx = 0; rpt_atomic = 0; rpt_uncached = 0;
        fill_valid = 0; fill_idx = 0; squash_vec = '0;
        defer_valid = 0; defer_idx = 0; rep_ready = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        drive_idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        #1;
        // R12: empty after reset, port idle.
        check(active == 1'b0, "R12", "active after reset", active, 0);
        check(rep_valid == 1'b0, "R12", "rep_valid after reset", rep_valid, 0);

        for (int r = 0; r < NV; r++) begin
            @(negedge clk);
            rpt_valid = VEC[r].rv; rpt_idx = VEC[r].ri;
            rpt_atomic = VEC[r].ra; rpt_uncached = VEC[r].ru;
            fill_valid = VEC[r].fv; fill_idx = VEC[r].fi;
            squash_vec = VEC[r].sq;
            defer_valid = VEC[r].dv; defer_idx = VEC[r].di;
            rep_ready = VEC[r].rr;
            #1;
            check(rep_valid == VEC[r].e_rv, row_tag(r), $sformatf("row %0d rep_valid", r), rep_valid, VEC[r].e_rv);
            if (VEC[r].e_rv) begin
                check(rep_idx == VEC[r].e_ri, row_tag(r), $sformatf("row %0d rep_idx", r), rep_idx, VEC[r].e_ri);
                check(rep_squashed == VEC[r].e_rs, row_tag(r), $sformatf("row %0d rep_squashed", r), rep_squashed, VEC[r].e_rs);
                check(rep_from_set == VEC[r].e_set, row_tag(r), $sformatf("row %0d rep_from_set", r), rep_from_set, VEC[r].e_set);
            end
            check(defer_ready == VEC[r].e_dr, "R10", $sformatf("row %0d defer_ready", r), defer_ready, VEC[r].e_dr);
            check(cancel_valid == VEC[r].rv, "R2", $sformatf("row %0d cancel_valid", r), cancel_valid, VEC[r].rv);
            if (VEC[r].rv)
                check(cancel_idx == VEC[r].ri, "R2", $sformatf("row %0d cancel_idx", r), cancel_idx, VEC[r].ri);
            check(slot_clr_valid == VEC[r].e_cl, "R3", $sformatf("row %0d slot_clr_valid", r), slot_clr_valid, VEC[r].e_cl);
            if (VEC[r].e_cl)
                check(slot_clr_idx == VEC[r].ri, "R3", $sformatf("row %0d slot_clr_idx", r), slot_clr_idx, VEC[r].ri);
            check(active == VEC[r].e_act, "R11", $sformatf("row %0d active", r), active, VEC[r].e_act);
        end

        // R1: a lone atomic report on an empty set parks nothing.
        @(negedge clk);
        drive_idle();
        rpt_valid = 1; rpt_idx = 4'd3; rpt_atomic = 1;
        @(negedge clk);
        drive_idle();
        #1;
        check(active == 1'b0, "R1", "active after atomic report", active, 0);

        // R7 then R12: insert with same-cycle fill, then reset mid-operation.
        @(negedge clk);
        rpt_valid = 1; rpt_idx = 4'd2; fill_valid = 1; fill_idx = 4'd2;
        @(negedge clk);
        drive_idle();
        #1;
        check(rep_valid == 1'b1 && rep_idx == 4'd2, "R7", "captured fill releases idx 2", {rep_valid, rep_idx}, {1'b1, 4'd2});
        @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        #1;
        check(active == 1'b0, "R12", "active after mid-run reset", active, 0);
        check(rep_valid == 1'b0, "R12", "rep_valid after mid-run reset", rep_valid, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule